// File: doc/BRIEF.md
# Pre-adder Multiply Pipeline

This block is the arithmetic front end of a multiply/add datapath. A signed 25-bit operand taken from the low bits of A is multiplied by a signed 18-bit B. When the per-cycle mode bit `pre_add` is set, the multiplier operand is first replaced by the 25-bit sum D + A. A second per-cycle mode bit, `cat_sel`, chooses what enters the post-adder: either the sign-extended product or the 48-bit concatenation of the full 30-bit A above the 18-bit B. The post-adder adds C to the chosen value and produces the 48-bit result P.

Every path has its own optional pipeline register, each with an individual clock enable and an active-high synchronous reset. The paths are A, B, C, D, the pre-adder result, the product, the two mode bits and P. The A and B chains have parameter lengths, and a length of zero removes them. Two cascade outputs tap the A and B chains at a parameter depth that must not exceed the chain length. An illegal combination stops elaboration. A global enable is ANDed into every stage enable, and a global reset is ORed into every stage reset. A reset always overrides a low enable.

Top module: `pam_pipe`

## Requirements
- R1: While the global reset `rst` is high, every stage clears at each clock edge, so `p`, `acout` and `bcout` read zero whatever the inputs are.
- R2: With `pre_add`=0 and `cat_sel`=0, `p` settles to C plus the signed product of A[24:0] and B. The product is sign-extended to 48 bits and the sum wraps modulo 2^48. A[29:25] have no effect on it.
- R3: With `pre_add`=1, the multiplier operand is (D + A[24:0]) truncated to 25 bits and read as signed, so 0xFFFFFF + 1 gives -2^24.
- R4: With `cat_sel`=1, `p` settles to {A[29:0], B[17:0]} + C modulo 2^48.
- R5: With default parameters, a change of `cat_sel` alone reaches `p` after exactly two rising edges: the mode register, then P.
- R6: With default parameters, a change of A in product mode reaches `p` after exactly four rising edges: A, pre-adder, product, P.
- R7: While `ce_p` is low, `p` holds its value when upstream inputs change. Once `ce_p` returns high, `p` takes the settled result at the next edge.
- R8: A high `rst_p` clears `p` at the next edge. A high `rst_m` clears the product register, so in product mode `p` becomes C.
- R9: While `en` is low and no reset is high, `p`, `acout` and `bcout` stay frozen. A global reset taken while `en` is low still clears them.
- R10: `acout` and `bcout` show A and B delayed by their own tap depth (one edge by default). With all lengths set to zero, they follow the inputs in the same cycle.
- R11: With every stage parameter zero and the C input disabled by parameter, `p` is a combinational function of A, B, D and the mode bits, and C is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Global synchronous reset, ORed into every stage reset |
| en | input | 1 | Global enable, ANDed into every stage enable |
| a | input | 30 | Operand A; low 25 bits feed the multiplier |
| b | input | 18 | Operand B, signed |
| c | input | 48 | Post-adder addend |
| d | input | 25 | Pre-adder operand |
| pre_add | input | 1 | 1: multiplier operand is D + A |
| cat_sel | input | 1 | 1: post-adder takes {A,B} instead of the product |
| ce_a | input | 1 | Enable of the A chain |
| ce_b | input | 1 | Enable of the B chain |
| ce_c | input | 1 | Enable of the C register |
| ce_d | input | 1 | Enable of the D register |
| ce_ad | input | 1 | Enable of the pre-adder result register |
| ce_m | input | 1 | Enable of the product register |
| ce_p | input | 1 | Enable of the P register |
| ce_mode | input | 1 | Enable of the mode-bit register |
| rst_a | input | 1 | Reset of the A chain |
| rst_b | input | 1 | Reset of the B chain |
| rst_c | input | 1 | Reset of the C register |
| rst_d | input | 1 | Reset of the D register |
| rst_ad | input | 1 | Reset of the pre-adder result register |
| rst_m | input | 1 | Reset of the product register |
| rst_p | input | 1 | Reset of the P register |
| rst_mode | input | 1 | Reset of the mode-bit register |
| p | output | 48 | Post-adder result |
| acout | output | 30 | A cascade tap |
| bcout | output | 18 | B cascade tap |

## Verification
Two functions can land in the same cycle: a global reset and a global enable held low. The bench provokes this by freezing the block with `en` low, changing every input, and then raising `rst` while `en` stays low. The result is judged at the ports. First `p` and both cascade taps must keep their old values, and then they must read zero one edge after the reset. A second collision is a change of `cat_sel` while products are still in flight. The bench toggles the mode with B steady and samples `p` at each edge, expecting the old result after one edge and the new one after two.

// File: rtl/pam_pkg.sv
package pam_pkg;
   localparam int MUL_A_W = 25;
   localparam int MUL_B_W = 18;
   localparam int PROD_W  = MUL_A_W + MUL_B_W;

   typedef struct packed {
      logic pre;
      logic cat;
   } pam_mode_t;
endpackage

// File: rtl/pam_delay.sv
module pam_delay #(
   parameter int W = 8,
   parameter int N = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ce,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (N == 0) begin : g_wire
         assign q = d;
      end else begin : g_reg
         logic [W-1:0] stg [1:N];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 1; i <= N; i++) stg[i] <= '0;
            end else if (ce) begin
               stg[1] <= d;
               for (int i = 2; i <= N; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[N];
      end
   endgenerate
endmodule

// File: rtl/pam_tapdelay.sv
module pam_tapdelay #(
   parameter int W   = 8,
   parameter int N   = 2,
   parameter int TAP = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ce,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] tap
);
   generate
      if (N == 0) begin : g_wire
         assign q   = d;
         assign tap = d;
      end else begin : g_reg
         logic [W-1:0] stg [1:N];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 1; i <= N; i++) stg[i] <= '0;
            end else if (ce) begin
               stg[1] <= d;
               for (int i = 2; i <= N; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[N];
         if (TAP == 0) begin : g_tap0
            assign tap = d;
         end else begin : g_tapn
            assign tap = stg[TAP];
         end
      end
   endgenerate
endmodule

// File: rtl/pam_preadd.sv
module pam_preadd #(
   parameter int W = 25
) (
   input  logic         pre,
   input  logic [W-1:0] a,
   input  logic [W-1:0] d,
   output logic [W-1:0] y
);
   always_comb begin
      if (pre) y = a + d;
      else     y = a;
   end
endmodule

// File: rtl/pam_mult.sv
module pam_mult #(
   parameter int AW = 25,
   parameter int BW = 18,
   localparam int PW = AW + BW
) (
   input  logic [AW-1:0] a,
   input  logic [BW-1:0] b,
   output logic [PW-1:0] p
);
   logic signed [PW-1:0] ax;
   logic signed [PW-1:0] bx;

   always_comb begin
      ax = PW'($signed(a));
      bx = PW'($signed(b));
      p  = ax * bx;
   end
endmodule

// File: rtl/pam_pipe.sv
module pam_pipe
   import pam_pkg::*;
#(
   parameter int A_W          = 30,
   parameter int B_W          = 18,
   parameter int P_W          = 48,
   parameter int D_W          = 25,
   parameter int A_STAGES     = 1,
   parameter int B_STAGES     = 2,
   parameter int ACASC_STAGES = 1,
   parameter int BCASC_STAGES = 1,
   parameter int C_REG        = 1,
   parameter int D_REG        = 1,
   parameter int AD_REG       = 1,
   parameter int M_REG        = 1,
   parameter int P_REG        = 1,
   parameter int MODE_REG     = 1,
   parameter bit HAS_C        = 1'b1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           en,
   input  logic [A_W-1:0] a,
   input  logic [B_W-1:0] b,
   input  logic [P_W-1:0] c,
   input  logic [D_W-1:0] d,
   input  logic           pre_add,
   input  logic           cat_sel,
   input  logic           ce_a,
   input  logic           ce_b,
   input  logic           ce_c,
   input  logic           ce_d,
   input  logic           ce_ad,
   input  logic           ce_m,
   input  logic           ce_p,
   input  logic           ce_mode,
   input  logic           rst_a,
   input  logic           rst_b,
   input  logic           rst_c,
   input  logic           rst_d,
   input  logic           rst_ad,
   input  logic           rst_m,
   input  logic           rst_p,
   input  logic           rst_mode,
   output logic [P_W-1:0] p,
   output logic [A_W-1:0] acout,
   output logic [B_W-1:0] bcout
);
   localparam int MW  = D_W;
   localparam int PRW = MW + B_W;
   localparam int EXT = P_W - PRW;

   // elaboration-time parameter checks
   generate
      if (ACASC_STAGES > A_STAGES || ACASC_STAGES < 0) begin : g_bad_acasc
         $fatal(1, "A cascade tap deeper than the A chain");
      end
      if (BCASC_STAGES > B_STAGES || BCASC_STAGES < 0) begin : g_bad_bcasc
         $fatal(1, "B cascade tap deeper than the B chain");
      end
      if (A_W + B_W != P_W) begin : g_bad_cat
         $fatal(1, "A and B widths must fill the result width");
      end
      if (MW != MUL_A_W || B_W != MUL_B_W || PRW != PROD_W) begin : g_bad_mul
         $fatal(1, "multiplier must be 25x18");
      end
      if (A_W < MW || EXT < 0) begin : g_bad_w
         $fatal(1, "A narrower than the multiplier operand");
      end
      if (C_REG > 1 || D_REG > 1 || AD_REG > 1 || M_REG > 1 || P_REG > 1 || MODE_REG > 1)
      begin : g_bad_reg
         $fatal(1, "single-register stages accept 0 or 1");
      end
   endgenerate

   // stage enables and resets with the global controls folded in
   logic ce_a_g, ce_b_g, ce_c_g, ce_d_g, ce_ad_g, ce_m_g, ce_p_g, ce_mode_g;
   logic rs_a_g, rs_b_g, rs_c_g, rs_d_g, rs_ad_g, rs_m_g, rs_p_g, rs_mode_g;

   assign ce_a_g    = ce_a    & en;
   assign ce_b_g    = ce_b    & en;
   assign ce_c_g    = ce_c    & en;
   assign ce_d_g    = ce_d    & en;
   assign ce_ad_g   = ce_ad   & en;
   assign ce_m_g    = ce_m    & en;
   assign ce_p_g    = ce_p    & en;
   assign ce_mode_g = ce_mode & en;
   assign rs_a_g    = rst_a    | rst;
   assign rs_b_g    = rst_b    | rst;
   assign rs_c_g    = rst_c    | rst;
   assign rs_d_g    = rst_d    | rst;
   assign rs_ad_g   = rst_ad   | rst;
   assign rs_m_g    = rst_m    | rst;
   assign rs_p_g    = rst_p    | rst;
   assign rs_mode_g = rst_mode | rst;

   // input chains
   logic [A_W-1:0] a_q;
   logic [B_W-1:0] b_q;
   logic [P_W-1:0] c_src, c_q;
   logic [D_W-1:0] d_q;
   pam_mode_t      mode_in, mode_q;

   pam_tapdelay #(.W(A_W), .N(A_STAGES), .TAP(ACASC_STAGES)) u_a (
      .clk(clk), .rst(rs_a_g), .ce(ce_a_g), .d(a), .q(a_q), .tap(acout));

   pam_tapdelay #(.W(B_W), .N(B_STAGES), .TAP(BCASC_STAGES)) u_b (
      .clk(clk), .rst(rs_b_g), .ce(ce_b_g), .d(b), .q(b_q), .tap(bcout));

   generate
      if (HAS_C) begin : g_c
         assign c_src = c;
      end else begin : g_noc
         assign c_src = '0;
      end
   endgenerate

   pam_delay #(.W(P_W), .N(C_REG)) u_c (
      .clk(clk), .rst(rs_c_g), .ce(ce_c_g), .d(c_src), .q(c_q));

   pam_delay #(.W(D_W), .N(D_REG)) u_d (
      .clk(clk), .rst(rs_d_g), .ce(ce_d_g), .d(d), .q(d_q));

   assign mode_in.pre = pre_add;
   assign mode_in.cat = cat_sel;

   pam_delay #(.W($bits(pam_mode_t)), .N(MODE_REG)) u_mode (
      .clk(clk), .rst(rs_mode_g), .ce(ce_mode_g), .d(mode_in), .q(mode_q));

   // pre-adder and multiplier
   logic [MW-1:0]  ad_comb, ad_q;
   logic [PRW-1:0] m_comb, m_q;

   pam_preadd #(.W(MW)) u_pre (
      .pre(mode_q.pre), .a(a_q[MW-1:0]), .d(d_q), .y(ad_comb));

   pam_delay #(.W(MW), .N(AD_REG)) u_ad (
      .clk(clk), .rst(rs_ad_g), .ce(ce_ad_g), .d(ad_comb), .q(ad_q));

   pam_mult #(.AW(MW), .BW(B_W)) u_mul (
      .a(ad_q), .b(b_q), .p(m_comb));

   pam_delay #(.W(PRW), .N(M_REG)) u_m (
      .clk(clk), .rst(rs_m_g), .ce(ce_m_g), .d(m_comb), .q(m_q));

   // post-adder
   logic [P_W-1:0] x_sel, sum;

   always_comb begin
      if (mode_q.cat) x_sel = {a_q, b_q};
      else            x_sel = {{EXT{m_q[PRW-1]}}, m_q};
      sum = x_sel + c_q;
   end

   pam_delay #(.W(P_W), .N(P_REG)) u_p (
      .clk(clk), .rst(rs_p_g), .ce(ce_p_g), .d(sum), .q(p));
endmodule

// File: rtl/pam_pipe_chk.sv
module pam_pipe_chk #(
   parameter int A_W          = 30,
   parameter int B_W          = 18,
   parameter int P_W          = 48,
   parameter int ACASC_STAGES = 1,
   parameter int BCASC_STAGES = 1,
   parameter int P_REG        = 1
) (
   input logic           clk,
   input logic           rst,
   input logic           en,
   input logic [A_W-1:0] a,
   input logic [B_W-1:0] b,
   input logic           ce_a,
   input logic           ce_b,
   input logic           ce_p,
   input logic           rst_a,
   input logic           rst_b,
   input logic           rst_p,
   input logic [P_W-1:0] p,
   input logic [A_W-1:0] acout,
   input logic [B_W-1:0] bcout
);
   generate
      if (P_REG == 1) begin : g_p
         // R8: stage reset of P clears the result at the next edge
         a_r8_p_clear: assert property (@(posedge clk) disable iff (rst)
            rst_p |=> (p == '0));
         // R7: P stage enable low holds the result
         a_r7_p_hold: assert property (@(posedge clk) disable iff (rst)
            (!ce_p && !rst_p) |=> $stable(p));
         // R9: global enable low freezes the result
         a_r9_p_freeze: assert property (@(posedge clk) disable iff (rst)
            (!en && !rst_p) |=> $stable(p));
      end
      if (ACASC_STAGES == 1) begin : g_ac
         // R10: A tap shows A one edge later
         a_r10_acout: assert property (@(posedge clk) disable iff (rst)
            (ce_a && en && !rst_a) |=> (acout == $past(a)));
         // R9: global enable low freezes the A tap
         a_r9_acout_freeze: assert property (@(posedge clk) disable iff (rst)
            (!en && !rst_a) |=> $stable(acout));
      end
      if (BCASC_STAGES == 1) begin : g_bc
         // R10: B tap shows B one edge later
         a_r10_bcout: assert property (@(posedge clk) disable iff (rst)
            (ce_b && en && !rst_b) |=> (bcout == $past(b)));
      end
   endgenerate
endmodule

bind pam_pipe pam_pipe_chk #(
   .A_W(A_W), .B_W(B_W), .P_W(P_W),
   .ACASC_STAGES(ACASC_STAGES), .BCASC_STAGES(BCASC_STAGES), .P_REG(P_REG)
) u_chk (
   .clk(clk), .rst(rst), .en(en), .a(a), .b(b),
   .ce_a(ce_a), .ce_b(ce_b), .ce_p(ce_p),
   .rst_a(rst_a), .rst_b(rst_b), .rst_p(rst_p),
   .p(p), .acout(acout), .bcout(bcout)
);

// File: tb/pam_pipe_tb.sv
module pam_pipe_tb;
   logic        clk = 1'b0;
   logic        rst, en;
   logic [29:0] a;
   logic [17:0] b;
   logic [47:0] c;
   logic [24:0] d;
   logic        pre_add, cat_sel;
   logic        ce_a, ce_b, ce_c, ce_d, ce_ad, ce_m, ce_p, ce_mode;
   logic        rst_a, rst_b, rst_c, rst_d, rst_ad, rst_m, rst_p, rst_mode;
   logic [47:0] p, p_z;
   logic [29:0] acout, acout_z;
   logic [17:0] bcout, bcout_z;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   pam_pipe u_dut (
      .clk(clk), .rst(rst), .en(en), .a(a), .b(b), .c(c), .d(d),
      .pre_add(pre_add), .cat_sel(cat_sel),
      .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c), .ce_d(ce_d), .ce_ad(ce_ad),
      .ce_m(ce_m), .ce_p(ce_p), .ce_mode(ce_mode),
      .rst_a(rst_a), .rst_b(rst_b), .rst_c(rst_c), .rst_d(rst_d), .rst_ad(rst_ad),
      .rst_m(rst_m), .rst_p(rst_p), .rst_mode(rst_mode),
      .p(p), .acout(acout), .bcout(bcout));

   pam_pipe #(
      .A_STAGES(0), .B_STAGES(0), .ACASC_STAGES(0), .BCASC_STAGES(0),
      .C_REG(0), .D_REG(0), .AD_REG(0), .M_REG(0), .P_REG(0), .MODE_REG(0),
      .HAS_C(1'b0)
   ) u_zero (
      .clk(clk), .rst(rst), .en(en), .a(a), .b(b), .c(c), .d(d),
      .pre_add(pre_add), .cat_sel(cat_sel),
      .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c), .ce_d(ce_d), .ce_ad(ce_ad),
      .ce_m(ce_m), .ce_p(ce_p), .ce_mode(ce_mode),
      .rst_a(rst_a), .rst_b(rst_b), .rst_c(rst_c), .rst_d(rst_d), .rst_ad(rst_ad),
      .rst_m(rst_m), .rst_p(rst_p), .rst_mode(rst_mode),
      .p(p_z), .acout(acout_z), .bcout(bcout_z));

   function automatic logic [47:0] model(logic [29:0] ma, logic [17:0] mb,
                                         logic [47:0] mc, logic [24:0] md,
                                         logic mpre, logic mcat, logic use_c);
      logic [24:0]        op;
      logic signed [42:0] ox, bx, prod;
      logic [47:0]        x;
      op   = mpre ? 25'(md + ma[24:0]) : ma[24:0];
      ox   = 43'($signed(op));
      bx   = 43'($signed(mb));
      prod = ox * bx;
      x    = mcat ? {ma, mb} : {{5{prod[42]}}, prod};
      return x + (use_c ? mc : 48'd0);
   endfunction

   task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_in(logic [29:0] na, logic [17:0] nb, logic [47:0] nc,
                         logic [24:0] nd, logic npre, logic ncat);
      a = na; b = nb; c = nc; d = nd; pre_add = npre; cat_sel = ncat;
   endtask

   task automatic t_reset;
      rst = 1'b1;
      set_in(30'h3000_1005, 18'd3, 48'd7, 25'd9, 1'b0, 1'b0);
      step(3);
      chk("R1 p", p, 48'd0);
      chk("R1 acout", 48'(acout), 48'd0);
      chk("R1 bcout", 48'(bcout), 48'd0);
      rst = 1'b0;
   endtask

   task automatic t_product;
      set_in(30'h3E00_04D2, 18'(-77), 48'd1000, 25'd0, 1'b0, 1'b0);
      step(6);
      chk("R2 product", p, model(a, b, c, d, 1'b0, 1'b0, 1'b1));
      chk("R11 zero-stage", p_z, model(a, b, c, d, 1'b0, 1'b0, 1'b0));
      set_in(30'h0100_0000, 18'h20000, 48'd0, 25'd0, 1'b0, 1'b0);
      step(6);
      chk("R2 min*min", p, model(a, b, c, d, 1'b0, 1'b0, 1'b1));
      set_in(30'h00FF_FFFF, 18'h1FFFF, 48'hFFFF_FFFF_FFFF, 25'd0, 1'b0, 1'b0);
      step(6);
      chk("R2 max*max-1", p, model(a, b, c, d, 1'b0, 1'b0, 1'b1));
   endtask

   task automatic t_preadd;
      set_in(30'd100, 18'd3, 48'd5, 25'(-30), 1'b1, 1'b0);
      step(6);
      chk("R3 preadd", p, 48'd215);
      chk("R11 zero-stage preadd", p_z, 48'd210);
      set_in(30'd1, 18'd2, 48'd0, 25'hFF_FFFF, 1'b1, 1'b0);
      step(6);
      chk("R3 preadd wrap", p, 48'hFFFF_FE00_0000);
   endtask

   task automatic t_concat;
      set_in(30'h1234_5678, 18'h2ABCD, 48'd1, 25'd0, 1'b0, 1'b1);
      step(6);
      chk("R4 concat", p, {30'h1234_5678, 18'h2ABCD} + 48'd1);
      chk("R11 zero-stage concat", p_z, {30'h1234_5678, 18'h2ABCD});
      set_in(30'h0000_0000, 18'h00005, 48'hFFFF_FFFF_FFFF, 25'd0, 1'b0, 1'b1);
      step(6);
      chk("R4 concat wrap", p, 48'd4);
   endtask

   task automatic t_latency;
      set_in(30'd10, 18'd10, 48'd0, 25'd0, 1'b0, 1'b0);
      step(6);
      a = 30'd20;
      step(3);
      chk("R6 latency 3 edges", p, 48'd100);
      step(1);
      chk("R6 latency 4 edges", p, 48'd200);
   endtask

   task automatic t_switch;
      set_in(30'd7, 18'd6, 48'd0, 25'd0, 1'b0, 1'b0);
      step(6);
      cat_sel = 1'b1;
      step(1);
      chk("R5 switch 1 edge", p, 48'd42);
      step(1);
      chk("R5 switch 2 edges", p, {30'd7, 18'd6});
      cat_sel = 1'b0;
      step(2);
      chk("R5 switch back", p, 48'd42);
   endtask

   task automatic t_ce_p;
      set_in(30'd3, 18'd5, 48'd0, 25'd0, 1'b0, 1'b0);
      step(6);
      ce_p = 1'b0;
      a = 30'd4;
      step(6);
      chk("R7 hold", p, 48'd15);
      ce_p = 1'b1;
      step(1);
      chk("R7 resume", p, 48'd20);
   endtask

   task automatic t_stage_rst;
      set_in(30'd9, 18'd9, 48'd100, 25'd0, 1'b0, 1'b0);
      step(6);
      rst_p = 1'b1;
      step(1);
      chk("R8 rst_p", p, 48'd0);
      rst_p = 1'b0;
      step(1);
      chk("R8 after rst_p", p, 48'd181);
      rst_m = 1'b1;
      step(2);
      chk("R8 rst_m", p, 48'd100);
      rst_m = 1'b0;
      step(2);
      chk("R8 after rst_m", p, 48'd181);
   endtask

   task automatic t_global;
      logic [47:0] p_old;
      logic [29:0] a_old;
      logic [17:0] b_old;
      set_in(30'd11, 18'd11, 48'd0, 25'd0, 1'b0, 1'b0);
      step(6);
      p_old = p; a_old = acout; b_old = bcout;
      en = 1'b0;
      set_in(30'd50, 18'd2, 48'd8, 25'd1, 1'b1, 1'b0);
      step(3);
      chk("R9 freeze p", p, p_old);
      chk("R9 freeze acout", 48'(acout), 48'(a_old));
      chk("R9 freeze bcout", 48'(bcout), 48'(b_old));
      rst = 1'b1;
      step(1);
      chk("R9 reset over enable p", p, 48'd0);
      chk("R9 reset over enable acout", 48'(acout), 48'd0);
      rst = 1'b0;
      en  = 1'b1;
      step(6);
      chk("R9 resume", p, model(a, b, c, d, 1'b1, 1'b0, 1'b1));
   endtask

   task automatic t_cascade;
      set_in(30'd1, 18'd1, 48'd0, 25'd0, 1'b0, 1'b0);
      step(6);
      a = 30'h2BAD_CAFE;
      b = 18'h1F00F;
      chk("R10 zero-stage acout", 48'(acout_z), 48'(30'h2BAD_CAFE));
      chk("R10 zero-stage bcout", 48'(bcout_z), 48'(18'h1F00F));
      step(1);
      chk("R10 acout", 48'(acout), 48'(30'h2BAD_CAFE));
      chk("R10 bcout", 48'(bcout), 48'(18'h1F00F));
   endtask

   initial begin
      #(20 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      en = 1'b1;
      {ce_a, ce_b, ce_c, ce_d, ce_ad, ce_m, ce_p, ce_mode} = '1;
      {rst_a, rst_b, rst_c, rst_d, rst_ad, rst_m, rst_p, rst_mode} = '0;
      rst = 1'b1;
      set_in('0, '0, '0, '0, 1'b0, 1'b0);
      t_reset();
      t_product();
      t_preadd();
      t_concat();
      t_latency();
      t_switch();
      t_ce_p();
      t_stage_rst();
      t_global();
      t_cascade();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule